// File: doc/BRIEF.md
# PRBS Pattern Lock and Bit-Error Detector

This block watches a received serial stream, one bit per cycle of the recovered receive clock, and checks it against a pseudo-random test sequence. It starts in a search state. In that state it loads the incoming bits into its own shift register, so its reference locks onto the incoming pattern by itself. After a run of consecutive bits that all agree with the reference's prediction, it declares lock. From then on the reference runs freely. Every received bit that differs from the prediction is reported as a bit error.

A single registered output carries both kinds of result. It stays high while the detector is searching. It is low while the detector is locked, apart from one-cycle high pulses, one for each errored bit. One control input picks the pattern length at run time: the 15-stage sequence or the 20-stage sequence. A 16-bit saturating counter can also collect the errors seen while locked. A host reads the counter as two bytes, and the read clears it. When too many errors fall inside a sliding 64-bit window, the detector leaves lock and searches again.

Top module: `prbs_sync_detector`

## Requirements
- R1: While reset is high and in the first cycle after it, `err_out` is 1 and `err_cnt` is 0.
- R2: With `long_sel` = 0 the expected bit is b[n] = b[n-15] XOR b[n-14] (polynomial x^15+x^14+1). With `long_sel` = 1 it is b[n] = b[n-20] XOR b[n-17] (polynomial x^20+x^17+1).
- R3: While searching, every received bit is loaded into the reference, and any mismatch restarts the run count. `err_out` is 1 throughout the search. It reads 0 in the cycle after the 32nd consecutive matching bit is sampled.
- R4: While locked, the reference runs freely. Each mismatched bit gives exactly one `err_out` high cycle, visible in the cycle after that bit is sampled. Matching bits give 0.
- R5: While locked with `cnt_en` = 1, each mismatched bit adds one to `err_cnt`.
- R6: With `cnt_en` = 0, a mismatched bit leaves `err_cnt` unchanged, but it still pulses `err_out`.
- R7: A cycle with `cnt_rd` = 1 clears `err_cnt` to 0. If a counted error arrives in that same cycle, `err_cnt` becomes 1 instead.
- R8: `err_cnt` saturates at all ones. It never wraps.
- R9: While locked, a mismatch that brings the errors in the latest 64 bits (this bit included) to 6 or more sends the detector back to search, and `err_out` stays high. Five errors in any 64-bit window keep lock.
- R10: A change of `long_sel` forces search at once. `err_out` reads 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received data bit, one per cycle |
| long_sel | input | 1 | Pattern length select: 0 = 15-stage, 1 = 20-stage |
| cnt_en | input | 1 | Routes locked bit errors into the counter |
| cnt_rd | input | 1 | Host read strobe; clears the counter |
| err_out | output | 1 | High while searching; one-cycle pulse per error while locked |
| err_cnt | output | CNT_W (16) | Saturating error count |

## Verification
The assertions check these on every cycle:
- `err_out` is high whenever the detector is out of lock.
- A change of the length select drops lock.
- The counter moves by at most one step without a read, holds when reporting is disabled, drops to 0 or 1 on a read, and stays at all ones once saturated.

Other behaviour needs the exact bit sequences of the bench's scenarios. These are:
- the precise acquisition cycle after an injected error in each pattern mode;
- the single pulse per errored bit;
- the 5-versus-6 error window boundary at spacings of 13 and 12 bits;
- relock exactly 32 bits after a loss;
- the bounded relock after a mode switch.

// File: rtl/prbs_sync_pkg.sv
`timescale 1ns/1ps
package prbs_sync_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } sync_st_e;
endpackage

// File: rtl/prbs_ref_gen.sv
`timescale 1ns/1ps
// Reference sequence register. It is loaded from the line while searching
// and from its own prediction while locked.
module prbs_ref_gen #(
  parameter int LEN_A = 15,
  parameter int TAP_A = 14,
  parameter int LEN_B = 20,
  parameter int TAP_B = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic long_sel,
  input  logic load_rx,
  output logic pred
);
  localparam int W = (LEN_A > LEN_B) ? LEN_A : LEN_B;

  logic [W-1:0] hist;

  always_comb begin
    if (long_sel) pred = hist[LEN_B-1] ^ hist[TAP_B-1];
    else          pred = hist[LEN_A-1] ^ hist[TAP_A-1];
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[W-2:0], load_rx ? rx_bit : pred};
  end
endmodule

// File: rtl/prbs_lock_fsm.sv
`timescale 1ns/1ps
// Search / lock control, sliding error window and the combined error output.
module prbs_lock_fsm
  import prbs_sync_pkg::*;
#(
  parameter int LOCK_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic pred,
  input  logic long_sel,
  output logic load_rx,
  output logic locked,
  output logic err_evt,
  output logic err_out
);
  localparam int MC_W = $clog2(LOCK_RUN);
  localparam int WC_W = $clog2(WIN) + 1;

  sync_st_e        st, st_n;
  logic [MC_W-1:0] mcnt, mcnt_n;
  logic [WIN-2:0]  ehist, ehist_n;
  logic [WC_W-1:0] wcnt, wcnt_n, wsum;
  logic            sel_q, sel_chg, mism, err_d;

  always_comb begin
    mism    = rx_bit ^ pred;
    sel_chg = long_sel ^ sel_q;
    wsum    = wcnt + WC_W'(mism);
    st_n    = st;
    mcnt_n  = mcnt;
    ehist_n = ehist;
    wcnt_n  = wcnt;
    err_d   = 1'b1;
    err_evt = 1'b0;
    case (st)
      ST_SEARCH: begin
        ehist_n = '0;
        wcnt_n  = '0;
        if (sel_chg || mism) begin
          mcnt_n = '0;
        end else if (mcnt == MC_W'(LOCK_RUN - 1)) begin
          st_n   = ST_LOCK;
          mcnt_n = '0;
          err_d  = 1'b0;
        end else begin
          mcnt_n = mcnt + 1'b1;
        end
      end
      default: begin
        if (sel_chg) begin
          st_n    = ST_SEARCH;
          mcnt_n  = '0;
          ehist_n = '0;
          wcnt_n  = '0;
        end else begin
          err_evt = mism;
          if (mism && (wsum >= WC_W'(LOSS_THR))) begin
            st_n    = ST_SEARCH;
            mcnt_n  = '0;
            ehist_n = '0;
            wcnt_n  = '0;
          end else begin
            err_d   = mism;
            ehist_n = {ehist[WIN-3:0], mism};
            wcnt_n  = wsum - WC_W'(ehist[WIN-2]);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    sel_q <= long_sel;
    if (rst) begin
      st      <= ST_SEARCH;
      mcnt    <= '0;
      ehist   <= '0;
      wcnt    <= '0;
      err_out <= 1'b1;
    end else begin
      st      <= st_n;
      mcnt    <= mcnt_n;
      ehist   <= ehist_n;
      wcnt    <= wcnt_n;
      err_out <= err_d;
    end
  end

  assign load_rx = (st == ST_SEARCH);
  assign locked  = (st == ST_LOCK);
endmodule

// File: rtl/prbs_err_counter.sv
`timescale 1ns/1ps
// Saturating error counter, cleared by a host read.
module prbs_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             en,
  input  logic             rd,
  output logic [CNT_W-1:0] cnt
);
  logic inc;
  assign inc = evt & en;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (rd)                  cnt <= inc ? CNT_W'(1) : '0;
    else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prbs_sync_detector.sv
`timescale 1ns/1ps
module prbs_sync_detector #(
  parameter int LEN_A    = 15,
  parameter int TAP_A    = 14,
  parameter int LEN_B    = 20,
  parameter int TAP_B    = 17,
  parameter int LOCK_RUN = 32,
  parameter int WIN      = 64,
  parameter int LOSS_THR = 6,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             long_sel,
  input  logic             cnt_en,
  input  logic             cnt_rd,
  output logic             err_out,
  output logic [CNT_W-1:0] err_cnt
);
  logic pred, load_rx, locked, err_evt;

  prbs_ref_gen #(
    .LEN_A(LEN_A), .TAP_A(TAP_A), .LEN_B(LEN_B), .TAP_B(TAP_B)
  ) u_ref (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .long_sel(long_sel),
    .load_rx(load_rx), .pred(pred)
  );

  prbs_lock_fsm #(
    .LOCK_RUN(LOCK_RUN), .WIN(WIN), .LOSS_THR(LOSS_THR)
  ) u_fsm (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .pred(pred), .long_sel(long_sel),
    .load_rx(load_rx), .locked(locked), .err_evt(err_evt), .err_out(err_out)
  );

  prbs_err_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .evt(err_evt), .en(cnt_en), .rd(cnt_rd),
    .cnt(err_cnt)
  );
endmodule

// File: rtl/prbs_sync_detector_chk.sv
`timescale 1ns/1ps
module prbs_sync_detector_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             long_sel,
  input logic             cnt_en,
  input logic             cnt_rd,
  input logic             err_out,
  input logic             locked,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  a_r3_search_high: assert property (@(posedge clk) disable iff (rst)
    !locked |-> err_out);

  a_r10_sel_drop: assert property (@(posedge clk) disable iff (rst)
    (long_sel != $past(long_sel)) |=> (!locked && err_out));

  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_rd |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

  a_r6_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cnt_rd) |=> $stable(err_cnt));

  a_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_rd |=> (err_cnt <= CNT_W'(1)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == ALL1 && !cnt_rd) |=> (err_cnt == ALL1));
endmodule

bind prbs_sync_detector prbs_sync_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .long_sel(long_sel), .cnt_en(cnt_en),
  .cnt_rd(cnt_rd), .err_out(err_out), .locked(locked), .err_cnt(err_cnt)
);

// File: tb/tb_prbs_sync_detector.sv
`timescale 1ns/1ps
module tb_prbs_sync_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_bit = 1'b0;
  logic        long_sel = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cnt_rd = 1'b0;
  logic        err_out, err_out_s;
  logic [15:0] err_cnt;
  logic [2:0]  err_cnt_s;
  logic [19:0] g = 20'h1;
  int          nchk = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  prbs_sync_detector dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .long_sel(long_sel),
    .cnt_en(cnt_en), .cnt_rd(cnt_rd), .err_out(err_out), .err_cnt(err_cnt)
  );

  prbs_sync_detector #(.CNT_W(3)) dut_sat (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .long_sel(long_sel),
    .cnt_en(cnt_en), .cnt_rd(cnt_rd), .err_out(err_out_s), .err_cnt(err_cnt_s)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bit of the selected sequence, optionally inverted, then sample.
  task automatic send(input logic flip);
    logic b;
    b = long_sel ? (g[19] ^ g[16]) : (g[14] ^ g[13]);
    g = {g[18:0], b};
    rx_bit = b ^ flip;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cnt_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(err_out === 1'b1, "R1", "err_out after reset", int'(err_out), 1);
    chk(err_cnt === 16'd0, "R1", "err_cnt after reset", int'(err_cnt), 0);
  endtask

  task automatic host_read(input logic flip);
    cnt_rd = 1'b1;
    send(flip);
    cnt_rd = 1'b0;
  endtask

  // R2/R3: error injected at bit 20; exact lock bit depends on the taps.
  task automatic t_acquire(input logic sel, input int lock_at);
    int bad = 0;
    long_sel = sel;
    do_reset();
    for (int i = 0; i <= lock_at; i++) begin
      send(i == 20);
      if (i < lock_at && err_out !== 1'b1) bad++;
    end
    chk(bad == 0, "R3", "err_out low before 32-bit run", bad, 0);
    chk(err_out === 1'b0, sel ? "R2 long mode lock bit" : "R2 short mode lock bit",
        "err_out at lock", int'(err_out), 0);
  endtask

  task automatic t_single_error();
    int bad = 0;
    cnt_en = 1'b1;
    host_read(1'b0);
    chk(err_cnt === 16'd0, "R7", "count after read", int'(err_cnt), 0);
    for (int i = 0; i < 10; i++) begin
      send(1'b0);
      if (err_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R4", "pulses on clean bits", bad, 0);
    send(1'b1);
    chk(err_out === 1'b1, "R4", "pulse on errored bit", int'(err_out), 1);
    send(1'b0);
    chk(err_out === 1'b0, "R4", "pulse width one bit", int'(err_out), 0);
    chk(err_cnt === 16'd1, "R5", "count after one error", int'(err_cnt), 1);
  endtask

  task automatic t_disabled_and_read();
    cnt_en = 1'b0;
    send(1'b1);
    chk(err_out === 1'b1, "R6", "pulse while disabled", int'(err_out), 1);
    send(1'b0);
    chk(err_cnt === 16'd1, "R6", "count held while disabled", int'(err_cnt), 1);
    cnt_en = 1'b1;
    host_read(1'b1);
    chk(err_cnt === 16'd1, "R7", "read with coincident error", int'(err_cnt), 1);
    host_read(1'b0);
    chk(err_cnt === 16'd0, "R7", "read clears", int'(err_cnt), 0);
    chk(err_cnt_s === 3'd0, "R7", "narrow counter read clears", int'(err_cnt_s), 0);
  endtask

  task automatic t_window();
    int bad = 0;
    repeat (70) send(1'b0);
    for (int k = 0; k < 6; k++) begin
      send(1'b1);
      if (k < 5) repeat (12) send(1'b0);
    end
    send(1'b0);
    chk(err_out === 1'b0, "R9", "lock kept at 13-bit spacing", int'(err_out), 0);
    chk(err_cnt === 16'd6, "R5", "count after six errors", int'(err_cnt), 6);
    for (int i = 0; i < 70; i++) begin
      send(1'b0);
      if (err_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R4", "no pulses on clean stream", bad, 0);
    for (int k = 0; k < 6; k++) begin
      send(1'b1);
      if (k < 5) repeat (11) send(1'b0);
    end
    bad = 0;
    for (int j = 1; j <= 32; j++) begin
      send(1'b0);
      if (j <= 31 && err_out !== 1'b1) bad++;
      if (j == 32)
        chk(err_out === 1'b0, "R9", "relock 32 bits after loss", int'(err_out), 0);
    end
    chk(bad == 0, "R9", "err_out low after loss", bad, 0);
    chk(err_cnt === 16'd12, "R5", "count after twelve errors", int'(err_cnt), 12);
    chk(err_cnt_s === 3'd7, "R8", "narrow counter saturated", int'(err_cnt_s), 7);
  endtask

  task automatic t_sel_change();
    int bad = 0;
    long_sel = ~long_sel;
    send(1'b0);
    chk(err_out === 1'b1, "R10", "search after select change", int'(err_out), 1);
    for (int j = 1; j <= 47; j++) begin
      send(1'b0);
      if (j <= 31 && err_out !== 1'b1) bad++;
      if (j == 47)
        chk(err_out === 1'b0, "R10", "relocked in new mode", int'(err_out), 0);
    end
    chk(bad == 0, "R10", "early lock after select change", bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_acquire(1'b0, 67);
    t_acquire(1'b1, 72);
    t_single_error();
    t_disabled_and_read();
    t_window();
    t_sel_change();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule